// File: doc/BRIEF.md
# Coherent I/Q Sample Read Port

This block is a read-only slave on a parallel processor bus. It returns an in-phase (I) value and a quadrature (Q) value, each 32 bits wide, and both come from the same sampling instant. The I and Q inputs change on a slow sampling clock. That clock enters the system clock domain as a plain signal, and a synchronizer finds its rising edges.

A read of the I location starts with the I access enable and an active-low read strobe. The acknowledge then drops to not-ready and stays low until the next detected sampling edge. On that edge both I and Q are frozen. The acknowledge then rises and I is driven onto the upper 32 lines of the 64-bit data bus. The frozen Q stays in its own register and is returned by a later read of the Q location, which acknowledges at once. The data outputs come with a drive-enable that controls the bus tri-state at the chip pads. The data outputs are zero whenever the port does not drive.

The controller has four states:
- IDLE: no access. The acknowledge is high and nothing is driven.
- ARMED: waiting for a sampling edge. The acknowledge is low.
- SERVE_I: returning the frozen I.
- SERVE_Q: returning the held Q.

The transitions are:
- IDLE to ARMED: an I read request.
- IDLE to SERVE_Q: a Q read request.
- ARMED to SERVE_I: a sampling edge arrives while the request is still held. This is the capture.
- ARMED to IDLE: the request is abandoned. This is an abort.
- SERVE_I to IDLE and SERVE_Q to IDLE: the read ends.

Top module: `iq_pair_port`

## Requirements
- R1: After reset, `ack_o` is 1, `bus_doe_o` is 0 and `bus_dout_o` is all zero.
- R2: An I read is requested when `sel_i` is 1 and `rd_n` is 0 in IDLE. One clock after that request is sampled, `ack_o` is 0 and `bus_doe_o` is 0.
- R3: `ack_o` stays 0 until the first synchronized rising edge of `samp_clk_i` that follows the request. It rises within three system clocks of that edge.
- R4: While the I read is acknowledged, `bus_doe_o` is 1. `bus_dout_o[63:32]` then carries the I value that was present at that sampling edge, and `bus_dout_o[31:0]` is always 0.
- R5: Q is captured on the same edge as I. A Q read (`sel_q` is 1 and `rd_n` is 0) never drives `ack_o` low. One clock after the request is sampled, it drives the held Q on `bus_dout_o[63:32]`.
- R6: The held Q is left unchanged by later sampling edges and by Q reads. Only the capture of a new I read replaces it.
- R7: An I read is aborted when `rd_n` rises or `sel_i` falls before the capture edge. The port then returns to IDLE with `ack_o` at 1 and `bus_doe_o` at 0, and it captures nothing.
- R8: One clock after a read ends, and whenever `rd_n` is 1, `bus_doe_o` is 0 and `bus_dout_o` is zero. A select with `rd_n` at 1 leaves `ack_o` at 1.
- R9: If `sel_i` and `sel_q` are both 1 when a read starts, the I read takes priority.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| samp_clk_i | input | 1 | Sampling clock, asynchronous to `clk` |
| i_in | input | 32 | In-phase sample, updated on the rising edge of `samp_clk_i` |
| q_in | input | 32 | Quadrature sample, updated on the rising edge of `samp_clk_i` |
| sel_i | input | 1 | Validated access enable for the I location |
| sel_q | input | 1 | Validated access enable for the Q location |
| rd_n | input | 1 | Read strobe, active low |
| ack_o | output | 1 | Acknowledge: 1 ready, 0 not ready |
| bus_dout_o | output | 64 | Read data; the result is on bits 63..32 |
| bus_doe_o | output | 1 | Drive enable for bits 63..32 at the pads |

## Verification
A controller stuck in ARMED shows up as an acknowledge that never rises after a sampling edge. A controller that leaves ARMED too early shows up as an acknowledge that rises before the edge, with data from the previous sample. Either error is visible within one sampling period of the request. A Q register that is overwritten at the wrong time is hidden until the next Q read. For that reason the directed tests wait several sampling periods, or run an abort or an ignored write, before reading Q. A lost priority or a missed abort appears one system clock after the request, on `ack_o` and `bus_doe_o`.

// File: rtl/iq_port_pkg.sv
package iq_port_pkg;

    localparam int unsigned SAMPLE_W = 32;
    localparam int unsigned BUS_W    = 64;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ARMED   = 2'd1,
        ST_SERVE_I = 2'd2,
        ST_SERVE_Q = 2'd3
    } port_state_t;

endpackage

// File: rtl/iq_edge_sync.sv
module iq_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);

    localparam int unsigned CHAIN = STAGES + 1;

    logic [CHAIN-1:0] chain_q;

    generate
        for (genvar g = 0; g < CHAIN; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= async_i;
                end
            end else begin : g_rest
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[g] <= 1'b0;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    // The last stage is the history bit; a rise is new-high and old-low.
    assign rise_o = chain_q[CHAIN-2] & ~chain_q[CHAIN-1];

endmodule

// File: rtl/iq_ctrl_fsm.sv
module iq_ctrl_fsm
    import iq_port_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sel_i,
    input  logic        sel_q,
    input  logic        rd_n,
    input  logic        edge_i,
    output port_state_t state_o,
    output logic        capture_o,
    output logic        ack_o,
    output logic        drive_i_o,
    output logic        drive_q_o
);

    port_state_t state_q, state_d;
    logic        i_req, q_req;

    assign i_req = sel_i & ~rd_n;
    assign q_req = sel_q & ~rd_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (i_req)      state_d = ST_ARMED;
                else if (q_req) state_d = ST_SERVE_Q;
            end
            ST_ARMED: begin
                if (!i_req)      state_d = ST_IDLE;
                else if (edge_i) state_d = ST_SERVE_I;
            end
            ST_SERVE_I: begin
                if (!i_req) state_d = ST_IDLE;
            end
            ST_SERVE_Q: begin
                if (!q_req) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        capture_o = 1'b0;
        ack_o     = 1'b1;
        drive_i_o = 1'b0;
        drive_q_o = 1'b0;
        unique case (state_q)
            ST_IDLE:    ;
            ST_ARMED: begin
                ack_o     = 1'b0;
                capture_o = edge_i & i_req;
            end
            ST_SERVE_I: drive_i_o = 1'b1;
            ST_SERVE_Q: drive_q_o = 1'b1;
            default:    ;
        endcase
    end

    assign state_o = state_q;

endmodule

// File: rtl/iq_hold_regs.sv
module iq_hold_regs #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         capture_i,
    input  logic [W-1:0] i_in,
    input  logic [W-1:0] q_in,
    output logic [W-1:0] i_hold_o,
    output logic [W-1:0] q_hold_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            i_hold_o <= '0;
            q_hold_o <= '0;
        end else if (capture_i) begin
            i_hold_o <= i_in;
            q_hold_o <= q_in;
        end
    end

endmodule

// File: rtl/iq_bus_drive.sv
module iq_bus_drive #(
    parameter int unsigned W     = 32,
    parameter int unsigned BUS_W = 64
) (
    input  logic             drive_i,
    input  logic             drive_q,
    input  logic [W-1:0]     i_hold,
    input  logic [W-1:0]     q_hold,
    output logic [BUS_W-1:0] dout_o,
    output logic             doe_o
);

    localparam int unsigned LOW_W = BUS_W - W;

    logic [W-1:0] word;

    always_comb begin
        word = '0;
        if (drive_i)      word = i_hold;
        else if (drive_q) word = q_hold;
    end

    assign dout_o = {word, {LOW_W{1'b0}}};
    assign doe_o  = drive_i | drive_q;

endmodule

// File: rtl/iq_pair_port.sv
module iq_pair_port
    import iq_port_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                samp_clk_i,
    input  logic [SAMPLE_W-1:0] i_in,
    input  logic [SAMPLE_W-1:0] q_in,
    input  logic                sel_i,
    input  logic                sel_q,
    input  logic                rd_n,
    output logic                ack_o,
    output logic [BUS_W-1:0]    bus_dout_o,
    output logic                bus_doe_o
);

    logic                samp_rise;
    logic                cap_pulse;
    logic                drv_i, drv_q;
    logic [SAMPLE_W-1:0] i_hold, q_hold;
    port_state_t         state;

    iq_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (samp_clk_i),
        .rise_o  (samp_rise)
    );

    iq_ctrl_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_i     (sel_i),
        .sel_q     (sel_q),
        .rd_n      (rd_n),
        .edge_i    (samp_rise),
        .state_o   (state),
        .capture_o (cap_pulse),
        .ack_o     (ack_o),
        .drive_i_o (drv_i),
        .drive_q_o (drv_q)
    );

    iq_hold_regs #(.W(SAMPLE_W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture_i (cap_pulse),
        .i_in      (i_in),
        .q_in      (q_in),
        .i_hold_o  (i_hold),
        .q_hold_o  (q_hold)
    );

    iq_bus_drive #(.W(SAMPLE_W), .BUS_W(BUS_W)) u_drv (
        .drive_i (drv_i),
        .drive_q (drv_q),
        .i_hold  (i_hold),
        .q_hold  (q_hold),
        .dout_o  (bus_dout_o),
        .doe_o   (bus_doe_o)
    );

endmodule

// File: rtl/iq_pair_port_chk.sv
module iq_pair_port_chk
    import iq_port_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                sel_i,
    input logic                rd_n,
    input port_state_t         st,
    input logic                rise,
    input logic                cap,
    input logic                ack,
    input logic                doe,
    input logic [BUS_W-1:0]    dout,
    input logic [SAMPLE_W-1:0] q_hold
);

    // R2
    start_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && sel_i && !rd_n) |=> !ack);

    // R3
    ack_after_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ack) && doe) |-> $past(rise));

    // R4
    low_half_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dout[BUS_W-SAMPLE_W-1:0] == '0);

    // R5
    q_read_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SERVE_Q) |-> ack);

    // R6
    q_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cap |=> $stable(q_hold));

    // R7
    abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ARMED && (rd_n || !sel_i)) |=> (ack && !doe));

    // R8
    quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !doe |-> (dout == '0));

endmodule

bind iq_pair_port iq_pair_port_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .sel_i  (sel_i),
    .rd_n   (rd_n),
    .st     (state),
    .rise   (samp_rise),
    .cap    (cap_pulse),
    .ack    (ack_o),
    .doe    (bus_doe_o),
    .dout   (bus_dout_o),
    .q_hold (q_hold)
);

// File: tb/sim_iq_pair_port.sv
module sim_iq_pair_port;

    localparam int HALF = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        samp = 1'b0;
    logic [31:0] i_in = '0, q_in = '0;
    logic        sel_i = 1'b0, sel_q = 1'b0, rd_n = 1'b1;
    logic        ack, doe;
    logic [63:0] dout;

    int checks = 0;
    int errors = 0;
    int idx = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    iq_pair_port u0 (
        .clk(clk), .rst_n(rst_n), .samp_clk_i(samp), .i_in(i_in), .q_in(q_in),
        .sel_i(sel_i), .sel_q(sel_q), .rd_n(rd_n),
        .ack_o(ack), .bus_dout_o(dout), .bus_doe_o(doe)
    );

    function automatic logic [31:0] exp_i(input int n);
        return 32'hA000_0000 + 32'(n) * 32'h11;
    endfunction

    function automatic logic [31:0] exp_q(input int n);
        return 32'h5000_0000 ^ (32'(n) * 32'h0101_0003);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                errors++;
                $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
                finish_run();
            end
        end
    end

    initial begin
        wait (rst_n);
        forever begin
            repeat (HALF) @(negedge clk);
            samp = ~samp;
            if (samp) begin
                idx++;
                i_in = exp_i(idx);
                q_in = exp_q(idx);
            end
        end
    end

    task automatic align_mid();
        @(posedge samp);
        repeat (8) @(negedge clk);
    endtask

    task automatic end_read();
        sel_i = 0; sel_q = 0; rd_n = 1;
        @(negedge clk);
        chk(!doe && dout == 0 && ack, "R8 bus released", {dout[63:1], doe}, 64'd0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(ack == 1'b1, "R1 ack", 64'(ack), 64'd1);
        chk(doe == 1'b0, "R1 doe", 64'(doe), 64'd0);
        chk(dout == 64'd0, "R1 dout", dout, 64'd0);
    endtask

    task automatic t_read_i(output int pair);
        int base, n;
        align_mid();
        base = idx;
        sel_i = 1; rd_n = 0;
        @(negedge clk);
        chk(ack == 1'b0 && doe == 1'b0, "R2 not ready", {ack, doe}, 64'd0);
        repeat (20) @(negedge clk);
        chk(ack == 1'b0, "R3 held before edge", 64'(ack), 64'd0);
        n = 0;
        while (!ack && n < 60) begin
            @(negedge clk);
            n++;
        end
        chk(ack == 1'b1 && n <= 6, "R3 ack after edge", 64'(n), 64'd6);
        chk(doe == 1'b1, "R4 doe", 64'(doe), 64'd1);
        chk(dout[63:32] == exp_i(base + 1), "R4 I data", 64'(dout[63:32]), 64'(exp_i(base + 1)));
        chk(dout[31:0] == 32'd0, "R4 low half", 64'(dout[31:0]), 64'd0);
        pair = base + 1;
        repeat (2) @(negedge clk);
        end_read();
    endtask

    task automatic t_read_q(input int pair, input string req);
        sel_q = 1; rd_n = 0;
        @(negedge clk);
        chk(ack == 1'b1, "R5 q ack", 64'(ack), 64'd1);
        chk(doe == 1'b1 && dout[63:32] == exp_q(pair), req, 64'(dout[63:32]), 64'(exp_q(pair)));
        @(negedge clk);
        chk(ack == 1'b1, "R5 q ack hold", 64'(ack), 64'd1);
        end_read();
    endtask

    task automatic t_abort(input int pair);
        align_mid();
        sel_i = 1; rd_n = 0;
        repeat (3) @(negedge clk);
        rd_n = 1; sel_i = 0;
        @(negedge clk);
        chk(ack == 1'b1 && doe == 1'b0, "R7 abort idle", {ack, doe}, 64'd2);
        repeat (2 * 2 * HALF) @(negedge clk);
        t_read_q(pair, "R7 no capture");
    endtask

    task automatic t_priority();
        int base, n;
        align_mid();
        base = idx;
        sel_i = 1; sel_q = 1; rd_n = 0;
        @(negedge clk);
        chk(ack == 1'b0, "R9 I wins", 64'(ack), 64'd0);
        n = 0;
        while (!ack && n < 60) begin
            @(negedge clk);
            n++;
        end
        chk(dout[63:32] == exp_i(base + 1), "R9 I data", 64'(dout[63:32]), 64'(exp_i(base + 1)));
        end_read();
        t_read_q(base + 1, "R9 pair Q");
    endtask

    task automatic t_write_ignored(input int pair);
        bit ok = 1;
        sel_i = 1; rd_n = 1;
        for (int k = 0; k < 3 * 2 * HALF; k++) begin
            @(negedge clk);
            if (!ack || doe) ok = 0;
        end
        chk(ok, "R8 select without read", {ack, doe}, 64'd2);
        sel_i = 0;
        t_read_q(pair, "R8 nothing captured");
    endtask

    initial begin
        int p;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        t_read_i(p);
        t_read_q(p, "R5 Q data");
        repeat (3 * 2 * HALF) @(negedge clk);
        t_read_q(p, "R6 Q held");
        t_abort(p);
        t_write_ignored(p);
        t_read_i(p);
        t_read_q(p, "R6 new pair replaces Q");
        t_priority();
        finish_run();
    end

endmodule